// File: doc/BRIEF.md
# Dual Baud Rate Timer

This block holds two independent reloadable 16-bit down-counters that turn a chosen clock-enable source into the sampling and bit-rate enables used by serial receivers and transmitters. Everything runs in one system clock domain. External clocks, pins and general inputs reach the block as one-cycle enable strobes. A free-running prescaler inside the block supplies the system clock divided by 16, 32, 64 and 128, and a toggle stage supplies half the X1 strobe rate.

Each counter produces a 16x enable, one pulse per divisor count of its selected source. A following divide-by-16 stage gives the 1x bit enable, so a serial channel clocked from this timer always works in 16x mode. Software programs the block through a plain byte write port: one shared control byte, and a low and a high divisor byte for each counter. The block has no streaming data path, so it has no valid/ready handshake. All pins are plain control and status.

Top module: `baud_timer_pair`

## Requirements
- R1: After reset the control byte and both divisors are 0. Neither counter runs, and no 16x or 1x pulse appears while the sources toggle.
- R2: A write goes to the control byte when `wr_addr` is 3'b000. A write goes to a divisor byte when `wr_addr[2]` is 1: bit 1 picks the counter (0 = a, 1 = b) and bit 0 picks the byte (0 = bits 7:0, 1 = bits 15:8). Writes to 3'b001, 3'b010 and 3'b011 change nothing.
- R3: In the control byte, bit 3 is the run bit of counter a and bits 2:0 are its source code. Bit 7 is the run bit of counter b and bits 6:4 are its source code.
- R4: The source codes are: 0 = system clock/16, 1 = /32, 2 = /64, 3 = /128, 4 = every X1 strobe, 5 = every second X1 strobe, 6 = that counter's own pin strobe (`pin_en[ch]`), 7 = that counter's own general strobe (`gin_en[ch]`).
- R5: While a counter runs, its 16x pulses repeat every D source strobes, where D is its divisor. With a periodic source of period P clocks, the pulses are D*P clocks apart.
- R6: The divisor is assembled from the two written bytes. The value 0 acts as 65536.
- R7: While its run bit is 0, a counter emits nothing and holds its count preloaded. After the run bit is set, the first 16x pulse appears in the D-th clock cycle, given a source that strobes every cycle.
- R8: A divisor written while a counter runs does not cut the period in progress. It takes effect at the next reload.
- R9: The 1x pulse occurs together with every 16th 16x pulse. The divide-by-16 stage clears while its counter is stopped, so after a restart the first 1x pulse coincides with the 16th 16x pulse.
- R10: Stopping, reconfiguring or running one counter has no effect on the pulse train of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| x1_en | input | 1 | X1 oscillator strobe |
| pin_en | input | 2 | Per-counter pin strobe (bit 0 = a, bit 1 = b) |
| gin_en | input | 2 | Per-counter general input strobe |
| tick16 | output | 2 | 16x enable per counter |
| tick1 | output | 2 | 1x bit enable per counter |

## Verification
The bench sweeps all eight source codes with several divisors on each counter and compares the measured pulse spacing with source period times divisor. A wrong tap in the prescaler or mux shows up as a wrong interval, and a swapped pin or general input shows up as counter b ticking at counter a's rate. It checks the restart latency of the 16x and 1x pulses, which catches a counter that is not preloaded or a divide-by-16 stage that keeps its phase across a stop. It also checks a divisor of 0, which a design that does not wrap would turn into a zero or one-count period, and a divisor changed mid-period, which an eager design would apply to the current count. Writes to unused addresses and work on one counter are done while the other counter runs, and its pulse train is checked for any change.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 2 * BYTE_W;
  localparam int N_CH     = 2;
  localparam int SEL_W    = 3;
  localparam int N_SRC    = 1 << SEL_W;
  localparam int ADDR_W   = 3;
  localparam int CTRL_FLD = BYTE_W / N_CH;

  // source vector bit positions (equal to the select code)
  localparam int SRC_SYS16  = 0;
  localparam int SRC_X1     = 4;
  localparam int SRC_X1HALF = 5;
  localparam int SRC_PIN    = 6;
  localparam int SRC_GIN    = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'b000;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
  import baud_pkg::*;
#(
  parameter int TAP_BASE = 4,
  parameter int N_TAPS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x1_en,
  output logic [N_TAPS-1:0] sys_en,
  output logic              x1_half
);
  localparam int PRE_W = TAP_BASE + N_TAPS - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic             x1_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      x1_phase <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (x1_en) x1_phase <= ~x1_phase;
    end
  end

  // tap g fires once every 2**(TAP_BASE+g) system clocks
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign sys_en[g] = &pre_cnt[TAP_BASE-1+g:0];
  end

  assign x1_half = x1_en & x1_phase;

  // R4: every slower tap lands on a faster one
  a_r4_taps_nest: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en[N_TAPS-1] |-> (&sys_en));
  a_r4_half_subset: assert property (@(posedge clk) disable iff (!rst_n)
    x1_half |-> x1_en);
  a_r4_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    x1_half |=> (!x1_half));
endmodule

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [N_CH-1:0]            run,
  output logic [N_CH-1:0][SEL_W-1:0] sel,
  output logic [N_CH-1:0][DIV_W-1:0] div
);
  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= wr_data;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              hit;

    assign hit = wr_en && wr_addr[2] && (wr_addr[1] == g[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        if (wr_addr[0]) hi_q <= wr_data;
        else            lo_q <= wr_data;
      end
    end

    assign div[g] = {hi_q, lo_q};
    assign run[g] = ctrl_q[g*CTRL_FLD + SEL_W];
    assign sel[g] = ctrl_q[g*CTRL_FLD +: SEL_W];
  end

  // R2: the three spare addresses leave all state untouched
  a_r2_spare_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[2] && wr_addr != ADDR_CTRL) |=>
      ($stable(ctrl_q) && $stable(div)));
endmodule

// File: rtl/baud_chan.sv
module baud_chan
  import baud_pkg::*;
#(
  parameter int SUB_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [N_SRC-1:0] src_vec,
  output logic             tick16,
  output logic             tick1
);
  logic [DIV_W-1:0]    cnt_q;
  logic [DIV_W-1:0]    reload;
  logic [SUB_LOG2-1:0] sub_q;
  logic                src_en;
  logic                at_tc;

  // a divisor of 0 wraps to all ones, giving 65536 counts
  assign reload = div - 1'b1;
  assign src_en = src_vec[sel];
  assign at_tc  = (cnt_q == '0);
  assign tick16 = run & src_en & at_tc;
  assign tick1  = tick16 & (&sub_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      sub_q <= '0;
    end else if (!run) begin
      cnt_q <= reload;
      sub_q <= '0;
    end else if (src_en) begin
      cnt_q <= at_tc ? reload : cnt_q - 1'b1;
      if (at_tc) sub_q <= sub_q + 1'b1;
    end
  end

  // R7: a stopped counter stays preloaded and its 1x stage stays cleared
  a_r7_stopped_preload: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(reload)));
  a_r9_sub_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sub_q == '0));
  // R5: one step down per source strobe
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_en && !at_tc) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R8: the reload uses the divisor seen at terminal count
  a_r8_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> (cnt_q == $past(reload)));
  // R5: no movement without a strobe
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src_en) |=> $stable(cnt_q) && $stable(sub_q));
endmodule

// File: rtl/baud_timer_pair.sv
module baud_timer_pair
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              x1_en,
  input  logic [N_CH-1:0]   pin_en,
  input  logic [N_CH-1:0]   gin_en,
  output logic [N_CH-1:0]   tick16,
  output logic [N_CH-1:0]   tick1
);
  localparam int N_TAPS = SRC_X1;

  logic [N_CH-1:0]            run;
  logic [N_CH-1:0][SEL_W-1:0] sel;
  logic [N_CH-1:0][DIV_W-1:0] div;
  logic [N_TAPS-1:0]          sys_en;
  logic                       x1_half;

  baud_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (run),
    .sel     (sel),
    .div     (div)
  );

  baud_prescale #(.TAP_BASE(4), .N_TAPS(N_TAPS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .x1_en   (x1_en),
    .sys_en  (sys_en),
    .x1_half (x1_half)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [N_SRC-1:0] src_vec;

    assign src_vec[SRC_SYS16 +: N_TAPS] = sys_en;
    assign src_vec[SRC_X1]              = x1_en;
    assign src_vec[SRC_X1HALF]          = x1_half;
    assign src_vec[SRC_PIN]             = pin_en[g];
    assign src_vec[SRC_GIN]             = gin_en[g];

    baud_chan #(.SUB_LOG2(4)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run[g]),
      .sel     (sel[g]),
      .div     (div[g]),
      .src_vec (src_vec),
      .tick16  (tick16[g]),
      .tick1   (tick1[g])
    );

    // R9: a bit enable never appears without its sampling enable
    a_r9_tick1_on_tick16: assert property (@(posedge clk) disable iff (!rst_n)
      tick1[g] |-> tick16[g]);
    // R7: a stopped counter is silent
    a_r7_silent_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run[g]) && !run[g] |-> !tick16[g]);
  end
endmodule

// File: tb/sim_baud_timer_pair.sv
module sim_baud_timer_pair;
  localparam int PER = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       x1_en = 1'b0;
  logic [1:0] pin_en = '0;
  logic [1:0] gin_en = '0;
  logic [1:0] tick16, tick1;

  baud_timer_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .x1_en(x1_en), .pin_en(pin_en), .gin_en(gin_en),
    .tick16(tick16), .tick1(tick1)
  );

  always #(PER/2) clk = ~clk;

  int     n_chk = 0, n_bad = 0;
  int     x1_per = 3;
  longint gc = 0;
  int     n16 [2] = '{0, 0};
  int     n1  [2] = '{0, 0};
  longint last16 [2] = '{0, 0};
  longint prev16 [2] = '{0, 0};
  longint last1  [2] = '{0, 0};
  longint prev1  [2] = '{0, 0};
  longint t_wr = 0;
  logic [7:0] ctrl_sh = '0;

  // source strobes: driven just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      gc++;
      x1_en     = (x1_per == 1) ? 1'b1 : (gc % x1_per == 0);
      pin_en[0] = (gc % 5 == 0);
      gin_en[0] = (gc % 7 == 0);
      pin_en[1] = (gc % 9 == 0);
      gin_en[1] = (gc % 11 == 0);
    end
  end

  // output monitor, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int c = 0; c < 2; c++) begin
          if (tick16[c]) begin n16[c]++; prev16[c] = last16[c]; last16[c] = $time; end
          if (tick1[c])  begin n1[c]++;  prev1[c]  = last1[c];  last1[c]  = $time; end
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 195000; k++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    t_wr = $time;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int ch, input int d);
    wr({1'b1, ch[0], 1'b0}, d[7:0]);
    wr({1'b1, ch[0], 1'b1}, d[15:8]);
  endtask

  task automatic set_ctrl(input int ch, input bit go, input int s);
    ctrl_sh[ch*4 +: 4] = {go, s[2:0]};
    wr(3'b000, ctrl_sh);
  endtask

  // wait for k more pulses (16x or 1x); ok = 0 on timeout
  task automatic wait_p(input int ch, input bit one, input int k, input int lim, output bit ok);
    int base;
    base = one ? n1[ch] : n16[ch];
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk);
      if ((one ? n1[ch] : n16[ch]) >= base + k) begin ok = 1'b1; break; end
    end
  endtask

  task automatic meas16(input int ch, input int lim, output longint cyc);
    bit ok;
    wait_p(ch, 1'b0, 2, lim, ok);
    cyc = ok ? (last16[ch] - prev16[ch]) / PER : -1;
  endtask

  int src_per_a [8] = '{16, 32, 64, 128, 3, 6, 5, 7};
  int src_per_b [8] = '{16, 32, 64, 128, 3, 6, 9, 11};

  initial begin
    longint cyc;
    int     keep;
    bit     ok;

    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: nothing after reset although every source strobes
    repeat (300) @(posedge clk);
    chk("R1 tick16 after reset", n16[0] + n16[1], 0);
    chk("R1 tick1 after reset", n1[0] + n1[1], 0);

    // R3: counter b via control bits 7:4, counter a untouched
    set_div(1, 2);
    set_ctrl(1, 1'b1, 0);
    meas16(1, 2000, cyc);
    chk("R3 counter b from upper control field", cyc, 32);
    chk("R3 counter a stays stopped", n16[0], 0);

    // R4 R5: sweep counter a over all sources and small divisors
    for (int s = 0; s < 8; s++) begin
      for (int d = 1; d <= 3; d++) begin
        set_ctrl(0, 1'b0, s);
        set_div(0, d);
        set_ctrl(0, 1'b1, s);
        meas16(0, 2000, cyc);
        chk($sformatf("R4 R5 counter a src=%0d div=%0d", s, d), cyc, src_per_a[s] * d);
      end
    end
    // R10: b kept its rate through all of that
    meas16(1, 2000, cyc);
    chk("R10 counter b unchanged by counter a work", cyc, 32);

    // R4 R10: sweep counter b while a is stopped
    set_ctrl(0, 1'b0, 0);
    keep = n16[0];
    for (int s = 0; s < 8; s++) begin
      set_ctrl(1, 1'b0, s);
      set_div(1, 2);
      set_ctrl(1, 1'b1, s);
      meas16(1, 2000, cyc);
      chk($sformatf("R4 counter b src=%0d div=2", s), cyc, src_per_b[s] * 2);
    end
    chk("R10 stopped counter a silent during b sweep", n16[0], keep);
    set_ctrl(1, 1'b0, 0);

    // R6: upper byte position, X1 every cycle
    x1_per = 1;
    set_div(0, 16'h0102);
    set_ctrl(0, 1'b1, 4);
    meas16(0, 2000, cyc);
    chk("R6 divisor 0x0102", cyc, 258);

    // R7: restart latency and silence while stopped
    set_ctrl(0, 1'b0, 4);
    set_div(0, 5);
    keep = n16[0];
    repeat (200) @(posedge clk);
    chk("R7 no pulses while stopped", n16[0], keep);
    set_ctrl(0, 1'b1, 4);
    wait_p(0, 1'b0, 1, 100, ok);
    chk("R7 first pulse after start", ok ? (last16[0] - t_wr) / PER : -1, 5);

    // R8: divisor change lands at the next reload
    set_ctrl(0, 1'b0, 4);
    set_div(0, 4);
    set_ctrl(0, 1'b1, 4);
    wait_p(0, 1'b0, 2, 100, ok);
    wr(3'b100, 8'd8);
    wait_p(0, 1'b0, 1, 100, ok);
    chk("R8 period in progress keeps old divisor", ok ? (last16[0] - prev16[0]) / PER : -1, 4);
    wait_p(0, 1'b0, 1, 100, ok);
    chk("R8 next period uses new divisor", ok ? (last16[0] - prev16[0]) / PER : -1, 8);

    // R2: spare addresses change nothing
    wr(3'b001, 8'h00);
    wr(3'b010, 8'h00);
    wr(3'b011, 8'h00);
    meas16(0, 200, cyc);
    chk("R2 spare address writes ignored", cyc, 8);

    // R9: 1x spacing, coincidence, clear on stop
    set_ctrl(0, 1'b0, 4);
    set_div(0, 3);
    set_ctrl(0, 1'b1, 4);
    wait_p(0, 1'b1, 2, 500, ok);
    chk("R9 1x spacing", ok ? (last1[0] - prev1[0]) / PER : -1, 48);
    chk("R9 1x coincides with 16x", last1[0], last16[0]);
    wait_p(0, 1'b0, 5, 100, ok);
    set_ctrl(0, 1'b0, 4);
    set_div(0, 1);
    set_ctrl(0, 1'b1, 4);
    wait_p(0, 1'b1, 1, 100, ok);
    chk("R9 first 1x after restart", ok ? (last1[0] - t_wr) / PER : -1, 16);

    // R6: divisor 0 counts 65536
    set_ctrl(0, 1'b0, 4);
    set_div(0, 0);
    set_ctrl(0, 1'b1, 4);
    wait_p(0, 1'b0, 1, 70000, ok);
    chk("R6 divisor 0 as 65536", ok ? (last16[0] - t_wr) / PER : -1, 65536);

    summary();
  end
endmodule